// File: doc/BRIEF.md
# Per-Core Timer and Software Interrupt Unit

This block gives each of a parameterised number of processor cores two interrupt sources. The first is a software-interrupt bit, which any agent on the register port can set or clear. The second is a timer interrupt, raised whenever the core's own 64-bit deadline register is at or below a shared 64-bit time counter. The time counter is free-running, advances by one on every cycle in which the tick-enable input is high, and cannot be written from the register port.

Software reaches all state through a 32-bit little-endian register port. A request lasts one cycle and carries an address, a write flag and write data. Read data appears on the cycle after the request. There are three address regions, and each base is a parameter:
- an array of software-interrupt words, one 4-byte word per core;
- an array of deadline registers, one 8-byte slot per core, each written and read as two 32-bit halves;
- a two-word window onto the time counter.

Timer outputs are levels. A core's timer output rises on its own once the counter catches up with the deadline. It falls only when software moves the deadline above the counter.

Top module: `hart_timer_ctrl`

## Requirements
- R1: A write to a core's software-interrupt word sets that core's `swi_o` bit to bit 0 of the write data, starting the cycle after the request. A read of the word returns the pending state in bit 0, with all other bits zero.
- R2: Core i's software-interrupt word is at `SWI_BASE + 4*i`. A write to one core's word leaves every other core's `swi_o` bit unchanged.
- R3: Core i's deadline is at `CMP_BASE + 8*i`, with bits 31:0 at offset 0 and bits 63:32 at offset 4. Writing one half replaces only that half, and both halves read back what was written.
- R4: `tti_o[i]` is high exactly when core i's deadline is less than or equal to the time counter. The comparison is made every cycle, so the output rises when the counter reaches the deadline, with no register write needed.
- R5: A deadline write that puts the deadline above the counter drives `tti_o[i]` low from the cycle after the request.
- R6: The time counter adds one on each clock edge at which `tick_en` is high and holds otherwise. It reads as bits 31:0 at `TIME_BASE` and bits 63:32 at `TIME_BASE + 4`, and it carries correctly from the low word into the high word.
- R7: Writes to either time-counter word leave the counter unchanged.
- R8: A read returns zero when its address is outside all regions, past the last core, or not a multiple of 4. A write to any such address changes no state.
- R9: Read data is registered and is valid on the cycle after a read request. On the cycle after any cycle with no read request, `rsp_rdata` is zero.
- R10: Reset, a synchronous active-low `rst_n`, clears every software-interrupt bit and every deadline to zero. It loads the time counter with `TIME_INIT`, which defaults to zero. Because a zero deadline is at or below the counter, every `tti_o` bit is high after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advance the time counter by one at this edge |
| req_valid | input | 1 | Register request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read request |
| swi_o | output | NCORES | Per-core software interrupt |
| tti_o | output | NCORES | Per-core timer interrupt level |

## Verification
The bench builds the block with three cores, so the decoder must handle a core count that is not a power of two. Under that setting, the word just past the last core falls inside the index field yet maps to no core. The three regions are placed close together at 0x000, 0x100 and 0x200. The counter starts at `TIME_INIT = 0xFFFF_FFF0`, which brings the carry into the high word, and a timer interrupt armed on that carry, within sixteen ticks.

// File: rtl/htc_pkg.sv
// Shared definitions for the per-core timer unit.
// Assumes: a 64-bit time base and 32-bit register words.
package htc_pkg;
    localparam int TIME_W = 64;
    localparam int WORD_W = 32;

    // Which register a request address selects.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SWI,
        SEL_CMP_LO,
        SEL_CMP_HI,
        SEL_TIME_LO,
        SEL_TIME_HI
    } htc_sel_e;
endpackage

// File: rtl/htc_time_base.sv
// Shared free-running time counter.
// Adds one on each edge where tick_en is high. It has no write path.
// Assumes: tick_en is already aligned to clk by the logic that makes the tick.
module htc_time_base
    import htc_pkg::*;
#(
    parameter logic [63:0] TIME_INIT = 64'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [TIME_W-1:0] count
);

    // Counter register: preset on reset, step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= TIME_INIT;
        else if (tick_en) count <= count + 64'd1;
    end

    a_r6_step : assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count == $past(count) + 64'd1);
    a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));

endmodule

// File: rtl/htc_addr_decode.sv
// Maps a byte address to a register select and a core index.
// Only addresses that are multiples of 4 can hit a register.
// Assumes: CMP_BASE is a multiple of 8, SWI_BASE and TIME_BASE are multiples of 4,
//          and the three regions do not overlap.
module htc_addr_decode
    import htc_pkg::*;
#(
    parameter int          NCORES    = 4,
    parameter int          ADDR_W    = 16,
    parameter int unsigned SWI_BASE  = 32'h0000,
    parameter int unsigned CMP_BASE  = 32'h4000,
    parameter int unsigned TIME_BASE = 32'hBFF8,
    localparam int         IDX_W     = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output htc_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);

    localparam int unsigned SWI_SPAN = 4 * NCORES;
    localparam int unsigned CMP_SPAN = 8 * NCORES;

    logic [31:0] a32;
    logic [31:0] swi_off;
    logic [31:0] cmp_off;

    assign a32     = 32'(addr);
    assign swi_off = a32 - SWI_BASE;
    assign cmp_off = a32 - CMP_BASE;

    // Region match: word-aligned addresses only, lowest region checked first.
    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (a32[1:0] == 2'b00) begin
            if (a32 >= SWI_BASE && swi_off < SWI_SPAN) begin
                sel = SEL_SWI;
                idx = IDX_W'(swi_off >> 2);
            end else if (a32 >= CMP_BASE && cmp_off < CMP_SPAN) begin
                sel = cmp_off[2] ? SEL_CMP_HI : SEL_CMP_LO;
                idx = IDX_W'(cmp_off >> 3);
            end else if (a32 == TIME_BASE) begin
                sel = SEL_TIME_LO;
            end else if (a32 == TIME_BASE + 32'd4) begin
                sel = SEL_TIME_HI;
            end
        end
    end

endmodule

// File: rtl/htc_core_slot.sv
// State for one core: its software-interrupt bit and its 64-bit deadline.
// The timer interrupt is a level that compares the deadline with the shared time.
// Assumes: at most one of the write strobes is high in any cycle.
module htc_core_slot
    import htc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_swi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic [TIME_W-1:0] time_now,
    output logic              swi,
    output logic [TIME_W-1:0] cmp,
    output logic              tti
);

    // Software-interrupt bit: follows bit 0 of each write to this core's word.
    always_ff @(posedge clk) begin
        if (!rst_n)      swi <= 1'b0;
        else if (wr_swi) swi <= wdata[0];
    end

    // Deadline: each half is replaced on its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
        end else begin
            if (wr_lo) cmp[31:0]  <= wdata;
            if (wr_hi) cmp[63:32] <= wdata;
        end
    end

    // Timer level: the deadline has been reached.
    assign tti = (cmp <= time_now);

    a_r1_swi_follow : assert property (@(posedge clk) disable iff (!rst_n)
        wr_swi |=> swi == $past(wdata[0]));
    a_r3_keep_hi : assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo && !wr_hi |=> cmp[63:32] == $past(cmp[63:32]));
    a_r3_keep_lo : assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi && !wr_lo |=> cmp[31:0] == $past(cmp[31:0]));
    a_r4_rise_cause : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tti) |-> $past(wr_lo || wr_hi) || (time_now != $past(time_now)));

endmodule

// File: rtl/hart_timer_ctrl.sv
// Per-core timer and software interrupt unit.
// One 32-bit register port reaches an array of software-interrupt words,
// an array of 64-bit deadlines and a read-only shared time counter.
// Assumes: a request is one cycle long, read data is taken the cycle after,
//          and each access is a full 32-bit word.
module hart_timer_ctrl
    import htc_pkg::*;
#(
    parameter int          NCORES    = 4,
    parameter int          ADDR_W    = 16,
    parameter int unsigned SWI_BASE  = 32'h0000,
    parameter int unsigned CMP_BASE  = 32'h4000,
    parameter int unsigned TIME_BASE = 32'hBFF8,
    parameter logic [63:0] TIME_INIT = 64'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic [NCORES-1:0] swi_o,
    output logic [NCORES-1:0] tti_o
);

    localparam int IDX_W = (NCORES > 1) ? $clog2(NCORES) : 1;

    htc_sel_e          sel;
    logic [IDX_W-1:0]  idx;
    logic [TIME_W-1:0] time_now;
    logic [TIME_W-1:0] cmp_all [NCORES];
    logic              wr_req;
    logic              rd_req;
    logic [31:0]       rd_mux;

    assign wr_req = req_valid && req_we;
    assign rd_req = req_valid && !req_we;

    htc_addr_decode #(
        .NCORES    (NCORES),
        .ADDR_W    (ADDR_W),
        .SWI_BASE  (SWI_BASE),
        .CMP_BASE  (CMP_BASE),
        .TIME_BASE (TIME_BASE)
    ) u_dec (
        .addr (req_addr),
        .sel  (sel),
        .idx  (idx)
    );

    a_r8_aligned_only : assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_addr[1:0] != 2'b00) |-> sel == SEL_NONE);

    htc_time_base #(
        .TIME_INIT (TIME_INIT)
    ) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count   (time_now)
    );

    a_r7_time_ro : assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && (sel == SEL_TIME_LO || sel == SEL_TIME_HI) && !tick_en
        |=> $stable(time_now));

    // One slot per core, each writing only when the index names it.
    for (genvar i = 0; i < NCORES; i++) begin : g_core
        logic hit;
        assign hit = wr_req && (idx == IDX_W'(i));

        htc_core_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_swi   (hit && sel == SEL_SWI),
            .wr_lo    (hit && sel == SEL_CMP_LO),
            .wr_hi    (hit && sel == SEL_CMP_HI),
            .wdata    (req_wdata),
            .time_now (time_now),
            .swi      (swi_o[i]),
            .cmp      (cmp_all[i]),
            .tti      (tti_o[i])
        );
    end

    // Read select: the addressed word, or zero when nothing is addressed.
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_SWI:     rd_mux = {31'd0, swi_o[idx]};
            SEL_CMP_LO:  rd_mux = cmp_all[idx][31:0];
            SEL_CMP_HI:  rd_mux = cmp_all[idx][63:32];
            SEL_TIME_LO: rd_mux = time_now[31:0];
            SEL_TIME_HI: rd_mux = time_now[63:32];
            default:     rd_mux = '0;
        endcase
    end

    // Response register: read data one cycle after the request, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (rd_req) rsp_rdata <= rd_mux;
        else             rsp_rdata <= '0;
    end

    a_r9_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> rsp_rdata == 32'd0);

endmodule

// File: tb/hart_timer_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue the expected word, and a monitor
// compares each queued word with the response one cycle later.
module hart_timer_ctrl_tb;

    localparam int          N    = 3;
    localparam int unsigned SWB  = 32'h000;
    localparam int unsigned CMB  = 32'h100;
    localparam int unsigned TMB  = 32'h200;
    localparam logic [63:0] TINI = 64'h0000_0000_FFFF_FFF0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [15:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rsp_rdata;
    logic [N-1:0]  swi_o;
    logic [N-1:0]  tti_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    hart_timer_ctrl #(
        .NCORES(N), .ADDR_W(16), .SWI_BASE(SWB), .CMP_BASE(CMB),
        .TIME_BASE(TMB), .TIME_INIT(TINI)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .swi_o(swi_o), .tti_o(tti_o)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(int unsigned a, logic [31:0] exp, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = 16'(a);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(int unsigned a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 16'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic tick(int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor: a read seen at the edge is compared with the next response.
    initial begin
        forever begin
            logic fire;
            @(posedge clk);
            fire = req_valid && !req_we;
            #1;
            if (fire && exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 64'(rsp_rdata), 64'(e));
            end
        end
    end

    initial begin
        #(4 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 swi after reset", 64'(swi_o), 64'd0);
        chk("R10 tti after reset", 64'(tti_o), 64'b111);
        rd(CMB + 8, 32'd0, "R10 core1 deadline lo");
        rd(CMB + 12, 32'd0, "R10 core1 deadline hi");
        rd(TMB, 32'hFFFF_FFF0, "R6 time lo preset");
        rd(TMB + 4, 32'd0, "R6 time hi preset");

        // R1 / R2 software interrupts
        wr(SWB + 4, 32'd3);
        chk("R1 core1 set by bit0", 64'(swi_o), 64'b010);
        rd(SWB + 4, 32'd1, "R1 core1 read pending");
        rd(SWB + 0, 32'd0, "R2 core0 untouched");
        wr(SWB + 8, 32'd1);
        chk("R2 core2 set, core1 kept", 64'(swi_o), 64'b110);
        wr(SWB + 4, 32'd2);
        chk("R1 core1 cleared by bit0", 64'(swi_o), 64'b100);
        rd(SWB + 8, 32'd1, "R2 core2 read");

        // R3 deadline halves, R5 deassert on a future deadline
        wr(CMB + 16, 32'h10);
        wr(CMB + 20, 32'h5);
        chk("R5 core2 tti low", 64'(tti_o), 64'b011);
        rd(CMB + 16, 32'h10, "R3 core2 lo");
        rd(CMB + 20, 32'h5, "R3 core2 hi");
        wr(CMB + 16, 32'h20);
        rd(CMB + 20, 32'h5, "R3 hi kept on lo write");
        rd(CMB + 16, 32'h20, "R3 lo replaced");
        rd(CMB + 8, 32'd0, "R3 core1 unaffected");
        wr(CMB + 4, 32'd1);
        chk("R5 core0 tti low after hi write", 64'(tti_o), 64'b010);

        // R4 rise by counting, R6 carry into the high word
        tick(15);
        chk("R4 core0 still low one tick short", 64'(tti_o), 64'b010);
        rd(TMB, 32'hFFFF_FFFF, "R6 time lo after 15");
        tick(1);
        chk("R4 core0 rises on reach", 64'(tti_o), 64'b011);
        rd(TMB, 32'd0, "R6 time lo wrapped");
        rd(TMB + 4, 32'd1, "R6 time hi carried");
        wr(CMB + 20, 32'd0);
        chk("R4 core2 rises on lower deadline", 64'(tti_o), 64'b111);

        // R7 time is read-only
        wr(TMB, 32'hDEAD_BEEF);
        wr(TMB + 4, 32'h7);
        rd(TMB, 32'd0, "R7 time lo unchanged");
        rd(TMB + 4, 32'd1, "R7 time hi unchanged");

        // R8 unmapped and misaligned
        rd(32'h300, 32'd0, "R8 unmapped read");
        rd(CMB + 2, 32'd0, "R8 misaligned deadline read");
        rd(SWB + 12, 32'd0, "R8 past last core read");
        rd(TMB + 8, 32'd0, "R8 past time read");
        wr(SWB + 12, 32'd1);
        chk("R8 past-core write no swi", 64'(swi_o), 64'b100);
        wr(SWB + 5, 32'd1);
        chk("R8 misaligned swi write", 64'(swi_o), 64'b100);
        wr(CMB + 1, 32'hFFFF_FFFF);
        rd(CMB + 0, 32'd0, "R8 misaligned deadline write");
        wr(CMB + 24, 32'hFFFF_FFFF);
        chk("R8 past-core deadline write", 64'(tti_o), 64'b111);

        // R9 response zero after a cycle without a read
        rd(SWB + 8, 32'd1, "R9 read valid next cycle");
        @(negedge clk);
        chk("R9 idle response zero", 64'(rsp_rdata), 64'd0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule